// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four Static Memory Model

This block is a synthesizable behavioural model of a synchronous static memory with separate write-data and read-data paths. A single address bus serves both directions. Each address names a group of four words, and each group moves as a four-beat burst. Everything runs on one clock at twice the rate of the memory's notional input clock. A free-running two-bit phase counter splits time into four-beat frames. Phase 0 is the read slot: a rising edge of the notional clock on which a read address may be taken. Phase 2 is the write slot, on the next rising edge of the notional clock. Phases 1 and 3 stand for the complementary clock edges. Each beat carries one word, so a read burst and a write burst can both run in every frame without any bus turnaround.

Writes are gathered beat by beat. The array is changed only when the fourth beat and its byte masks arrive, and the whole group is committed at once. A read fetches its four words one edge after its address is captured. At that same edge, a write still in flight to the same group is merged in lane by lane. A read therefore always returns the newest data written before it. The fetched group then passes through a delay line of `RD_LAT-2` stages and is shifted out one word per cycle with a valid flag. When no read burst is being delivered, the data output is held at zero.

Top module: `qdr_sram`

## Requirements
- R1: After reset `cyclePhase` counts 0,1,2,3,0,... by one per clock. `echoStrobe` is high exactly in the cycles where `cyclePhase` is odd, which are the cycles just after a rising edge of the notional clock.
- R2: A read address is taken from `addr` only at an edge where `cyclePhase` is 0 and `rdSelN` is low. `rdSelN` low at any other phase is ignored and produces no output.
- R3: A write address is taken only at an edge where `cyclePhase` is 2 and `wrSelN` is low. Words 0,1,2,3 of the group are taken from `din`/`bwN` at that edge and at the three edges that follow. `wrSelN` low at any other phase is ignored.
- R4: Byte lane 0 is bits [8:0] and byte lane 1 is bits [17:9]. `bwN[k]` low writes lane k of that beat's word. A high `bwN[k]` leaves that lane unchanged, and a beat with both bits high writes nothing.
- R5: For a read taken at edge E, word b of the group (internal word address {addr, b}) is on `dout` with `doutValid` high just after edge E+RD_LAT+b (default RD_LAT = 3), for b = 0..3 in ascending order.
- R6: Whenever no read beat is being delivered, `doutValid` is low and `dout` is zero.
- R7: A read taken in the read slot right after a write to the same group returns the write's new lanes merged over the older contents. A write taken later in the same frame as a read does not affect that read.
- R8: With a read and a write issued in every frame, the output carries one valid word every cycle with no gaps and no collisions.
- R9: While reset is held, `cyclePhase` is 0, `echoStrobe` is 0, `doutValid` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W (8) | Shared group address: read address in phase 0, write address in phase 2 |
| rdSelN | input | 1 | Read select, active low, sampled in phase 0 |
| wrSelN | input | 1 | Write select, active low, sampled in phase 2 |
| bwN | input | NUM_BYTES (2) | Per-lane write masks, active low, one set per write beat |
| din | input | WORD_W (18) | Write data word, one per write beat |
| dout | output | WORD_W (18) | Read data word, zero when idle |
| doutValid | output | 1 | High while `dout` carries a read beat |
| echoStrobe | output | 1 | Strobe that toggles every cycle, high after notional rising edges |
| cyclePhase | output | 2 | Frame phase: 0 = read slot, 2 = write slot |

## Verification
The checker assumes that inputs change only between clock edges. It also assumes that select pulses are meant for the phase they land in, and that each burst's output start and end fall on phase (RD_LAT+1) mod 4, which holds because reads are accepted only in phase 0. The array has no reset, so the stimulus fills every group before any group is read. The stimulus also advances strictly in four-cycle frames aligned to phase 0. Select and address noise is driven only in the phases where the block must ignore it, which keeps burst boundaries on the expected phase.

// File: rtl/qdr_sram_pkg.sv
package qdr_sram_pkg;

  // Per-edge strobes from the controller to the datapath.
  typedef struct packed {
    logic       rdCap;     // take read address this edge
    logic       wrCap;     // take write address this edge
    logic       wrBeat;    // a write beat is on din/bwN this edge
    logic [1:0] wrIdx;     // which word of the group that beat is
    logic       wrCommit;  // last beat: update the array
    logic       fetch;     // read the addressed group (with forwarding)
    logic       serLoad;   // start shifting out a delayed group
    logic       serShift;  // continue shifting out
  } qdrStrobe_t;

endpackage

// File: rtl/qdr_sram_ctrl.sv
module qdr_sram_ctrl
  import qdr_sram_pkg::*;
#(
  parameter int RD_LAT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rdSelN,
  input  logic       wrSelN,
  output qdrStrobe_t strobe,
  output logic [1:0] cyclePhase,
  output logic       echoStrobe,
  output logic       doutValid
);

  localparam int CHAIN = RD_LAT - 2;
  localparam logic [1:0] LAST_BEAT = 2'd3;

  logic [1:0] phase;
  logic       echoQ;
  logic       wrBusy;
  logic [1:0] wrCnt;
  logic       rdPend;
  logic       fetchVal;
  logic [1:0] outLeft;
  logic       outValid;
  logic       serLoadSig;
  logic       rdCapSig;
  logic       wrCapSig;

  assign rdCapSig = (phase == 2'd0) && !rdSelN;
  assign wrCapSig = (phase == 2'd2) && !wrSelN;

  // Valid flag travels alongside the delayed group in the datapath.
  generate
    if (CHAIN == 0) begin : gNoDelay
      assign serLoadSig = fetchVal;
    end else begin : gDelay
      logic [CHAIN-1:0] vq;
      always_ff @(posedge clk) begin
        if (rst) begin
          vq <= '0;
        end else begin
          vq[0] <= fetchVal;
          for (int i = 1; i < CHAIN; i++) vq[i] <= vq[i-1];
        end
      end
      assign serLoadSig = vq[CHAIN-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 2'd0;
      echoQ    <= 1'b0;
      wrBusy   <= 1'b0;
      wrCnt    <= 2'd0;
      rdPend   <= 1'b0;
      fetchVal <= 1'b0;
      outLeft  <= 2'd0;
      outValid <= 1'b0;
    end else begin
      phase    <= phase + 2'd1;
      echoQ    <= ~phase[0];
      rdPend   <= rdCapSig;
      fetchVal <= rdPend;
      if (wrCapSig) begin
        wrBusy <= 1'b1;
        wrCnt  <= 2'd1;
      end else if (wrBusy) begin
        wrCnt <= wrCnt + 2'd1;
        if (wrCnt == LAST_BEAT) wrBusy <= 1'b0;
      end
      if (serLoadSig) begin
        outValid <= 1'b1;
        outLeft  <= 2'd3;
      end else if (outLeft != 2'd0) begin
        outValid <= 1'b1;
        outLeft  <= outLeft - 2'd1;
      end else begin
        outValid <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.rdCap    = rdCapSig;
    strobe.wrCap    = wrCapSig;
    strobe.wrBeat   = wrCapSig || wrBusy;
    strobe.wrIdx    = wrCapSig ? 2'd0 : wrCnt;
    strobe.wrCommit = wrBusy && (wrCnt == LAST_BEAT);
    strobe.fetch    = rdPend;
    strobe.serLoad  = serLoadSig;
    strobe.serShift = !serLoadSig && (outLeft != 2'd0);
  end

  assign cyclePhase = phase;
  assign echoStrobe = echoQ;
  assign doutValid  = outValid;

endmodule

// File: rtl/qdr_sram_dpath.sv
module qdr_sram_dpath
  import qdr_sram_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int BYTE_W    = 9,
  parameter int DEPTH     = 256,
  parameter int RD_LAT    = 3,
  parameter int ADDR_W    = $clog2(DEPTH),
  parameter int NUM_BYTES = WORD_W / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  qdrStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BYTES-1:0] bwN,
  input  logic [WORD_W-1:0]    din,
  output logic [WORD_W-1:0]    dout
);

  localparam int BURST     = 4;
  localparam int CHAIN     = RD_LAT - 2;
  localparam int MEM_WORDS = DEPTH * BURST;
  localparam int GROUP_W   = BURST * WORD_W;

  logic [WORD_W-1:0]        mem [MEM_WORDS];
  logic [ADDR_W-1:0]        rdAddr;
  logic [ADDR_W-1:0]        wrAddr;
  logic [WORD_W-1:0]        wbuf [BURST-1];
  logic [NUM_BYTES-1:0]     wbw  [BURST-1];
  logic [WORD_W-1:0]        cData [BURST];
  logic [NUM_BYTES-1:0]     cMask [BURST];
  logic [GROUP_W-1:0]       fetchNext;
  logic [GROUP_W-1:0]       fetchBuf;
  logic [GROUP_W-1:0]       serIn;
  logic [GROUP_W-WORD_W-1:0] hold;
  logic [WORD_W-1:0]        doutQ;
  logic                     fwdHit;

  // Group being committed: three buffered beats plus the live last beat.
  always_comb begin
    for (int b = 0; b < BURST - 1; b++) begin
      cData[b] = wbuf[b];
      cMask[b] = wbw[b];
    end
    cData[BURST-1] = din;
    cMask[BURST-1] = bwN;
  end

  assign fwdHit = strobe.wrCommit && (wrAddr == rdAddr);

  // Group fetch with lane-wise forwarding of the write committing now.
  always_comb begin
    fetchNext = '0;
    for (int b = 0; b < BURST; b++) begin
      fetchNext[b*WORD_W +: WORD_W] = mem[{rdAddr, 2'(b)}];
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (fwdHit && !cMask[b][k])
          fetchNext[b*WORD_W + k*BYTE_W +: BYTE_W] = cData[b][k*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrCommit) begin
      for (int b = 0; b < BURST; b++) begin
        for (int k = 0; k < NUM_BYTES; k++) begin
          if (!cMask[b][k])
            mem[{wrAddr, 2'(b)}][k*BYTE_W +: BYTE_W] <= cData[b][k*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdAddr   <= '0;
      wrAddr   <= '0;
      fetchBuf <= '0;
      hold     <= '0;
      doutQ    <= '0;
      for (int b = 0; b < BURST - 1; b++) begin
        wbuf[b] <= '0;
        wbw[b]  <= '1;
      end
    end else begin
      if (strobe.rdCap) rdAddr <= addr;
      if (strobe.wrCap) wrAddr <= addr;
      for (int b = 0; b < BURST - 1; b++) begin
        if (strobe.wrBeat && strobe.wrIdx == 2'(b)) begin
          wbuf[b] <= din;
          wbw[b]  <= bwN;
        end
      end
      if (strobe.fetch) fetchBuf <= fetchNext;
      if (strobe.serLoad) begin
        doutQ <= serIn[WORD_W-1:0];
        hold  <= serIn[GROUP_W-1:WORD_W];
      end else if (strobe.serShift) begin
        doutQ <= hold[WORD_W-1:0];
        hold  <= hold >> WORD_W;
      end else begin
        doutQ <= '0;
      end
    end
  end

  generate
    if (CHAIN == 0) begin : gNoDelay
      assign serIn = fetchBuf;
    end else begin : gDelay
      logic [GROUP_W-1:0] stage [CHAIN];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < CHAIN; i++) stage[i] <= '0;
        end else begin
          stage[0] <= fetchBuf;
          for (int i = 1; i < CHAIN; i++) stage[i] <= stage[i-1];
        end
      end
      assign serIn = stage[CHAIN-1];
    end
  endgenerate

  assign dout = doutQ;

endmodule

// File: rtl/qdr_sram.sv
module qdr_sram
  import qdr_sram_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int BYTE_W    = 9,
  parameter int DEPTH     = 256,
  parameter int RD_LAT    = 3,
  parameter int ADDR_W    = $clog2(DEPTH),
  parameter int NUM_BYTES = WORD_W / BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rdSelN,
  input  logic                 wrSelN,
  input  logic [NUM_BYTES-1:0] bwN,
  input  logic [WORD_W-1:0]    din,
  output logic [WORD_W-1:0]    dout,
  output logic                 doutValid,
  output logic                 echoStrobe,
  output logic [1:0]           cyclePhase
);

  qdrStrobe_t strobe;

  qdr_sram_ctrl #(.RD_LAT(RD_LAT)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .rdSelN    (rdSelN),
    .wrSelN    (wrSelN),
    .strobe    (strobe),
    .cyclePhase(cyclePhase),
    .echoStrobe(echoStrobe),
    .doutValid (doutValid)
  );

  qdr_sram_dpath #(
    .WORD_W   (WORD_W),
    .BYTE_W   (BYTE_W),
    .DEPTH    (DEPTH),
    .RD_LAT   (RD_LAT),
    .ADDR_W   (ADDR_W),
    .NUM_BYTES(NUM_BYTES)
  ) uDpath (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .addr  (addr),
    .bwN   (bwN),
    .din   (din),
    .dout  (dout)
  );

endmodule

// File: rtl/qdr_sram_chk.sv
module qdr_sram_chk #(
  parameter int WORD_W = 18,
  parameter int RD_LAT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rdSelN,
  input logic [WORD_W-1:0] dout,
  input logic              doutValid,
  input logic              echoStrobe,
  input logic [1:0]        cyclePhase
);

  localparam logic [1:0] EDGE_PHASE = 2'((RD_LAT + 1) % 4);

  logic        armed;
  logic [31:0] readsSeen;
  logic [31:0] beatsOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      readsSeen <= '0;
      beatsOut  <= '0;
    end else begin
      armed <= 1'b1;
      if (cyclePhase == 2'd0 && !rdSelN) readsSeen <= readsSeen + 32'd1;
      if (doutValid) beatsOut <= beatsOut + 32'd1;
    end
  end

  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    cyclePhase == $past(cyclePhase) + 2'd1);

  p_echo_toggle_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    echoStrobe != $past(echoStrobe));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !doutValid |-> dout == '0);

  p_burst_start_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(doutValid) |-> cyclePhase == EDGE_PHASE);

  p_burst_end_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(doutValid) |-> cyclePhase == EDGE_PHASE);

  p_no_orphan_r2: assert property (@(posedge clk) disable iff (rst)
    beatsOut <= {readsSeen[29:0], 2'b00});

endmodule

bind qdr_sram qdr_sram_chk #(.WORD_W(WORD_W), .RD_LAT(RD_LAT)) uChk (
  .clk       (clk),
  .rst       (rst),
  .rdSelN    (rdSelN),
  .dout      (dout),
  .doutValid (doutValid),
  .echoStrobe(echoStrobe),
  .cyclePhase(cyclePhase)
);

// File: tb/tb_qdr_sram.sv
module tb_qdr_sram;

  localparam int PERIOD = 10;
  localparam int W      = 18;
  localparam int LANE   = 9;
  localparam int DEPTH  = 16;
  localparam int AW     = 4;
  localparam int LAT    = 3;

  logic          clk;
  logic          rst;
  logic [AW-1:0] addr;
  logic          rdSelN;
  logic          wrSelN;
  logic [1:0]    bwN;
  logic [W-1:0]  din;
  logic [W-1:0]  dout;
  logic          doutValid;
  logic          echoStrobe;
  logic [1:0]    cyclePhase;

  qdr_sram #(.WORD_W(W), .BYTE_W(LANE), .DEPTH(DEPTH), .RD_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .addr(addr), .rdSelN(rdSelN), .wrSelN(wrSelN),
    .bwN(bwN), .din(din), .dout(dout), .doutValid(doutValid),
    .echoStrobe(echoStrobe), .cyclePhase(cyclePhase)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int unsigned  edgeCnt = 0;
  always @(posedge clk) edgeCnt++;

  logic [W-1:0] shadow [DEPTH*4];
  bit           expV [64];
  logic [W-1:0] expD [64];
  logic [2*W-1:0] carryD = '0;
  logic [3:0]   carryB = 4'hF;
  int           checks = 0;
  int           errors = 0;
  bit           monOn  = 1'b0;
  bit           done   = 1'b0;
  logic [31:0]  seed   = 32'h1234_5678;

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Output monitor: every cycle, R5 order/latency, R6 idle zero, R7 merged data, R8 continuity.
  always @(negedge clk) begin
    if (monOn) begin
      int i;
      logic [W-1:0] e;
      i = int'(edgeCnt % 64);
      e = expV[i] ? expD[i] : '0;
      checks++;
      if (doutValid !== expV[i] || dout !== e) begin
        errors++;
        $display("FAIL R5/R6/R7 cycle %0d: actual valid=%b data=%h expected valid=%b data=%h",
                 edgeCnt, doutValid, dout, expV[i], e);
      end
      expV[i] = 1'b0;
    end
  end

  // One four-cycle frame, entered at the negedge before a phase-0 edge.
  task automatic frame(input bit rdEn, input logic [AW-1:0] rdA,
                       input bit wrEn, input logic [AW-1:0] wrA, input bit noise,
                       input logic [4*W-1:0] dq, input logic [7:0] bq);
    int cap;
    check(cyclePhase == 2'd0, "R1", "phase at frame start", W'(cyclePhase), '0);
    check(echoStrobe == 1'b0, "R1", "echo in even phase", W'(echoStrobe), '0);
    if (rdEn) begin
      cap = int'(edgeCnt) + 1;
      for (int b = 0; b < 4; b++) begin
        expV[(cap + LAT + b) % 64] = 1'b1;
        expD[(cap + LAT + b) % 64] = shadow[{rdA, 2'(b)}];
      end
    end
    // phase 0: read slot, beat 2 of previous write; R3 wrSelN noise ignored
    rdSelN = !rdEn; addr = rdA; wrSelN = !noise;
    din = carryD[W-1:0]; bwN = carryB[1:0];
    @(negedge clk);
    check(echoStrobe == 1'b1, "R1", "echo in odd phase", W'(echoStrobe), W'(1));
    // phase 1: R2 and R3 noise ignored
    rdSelN = !noise; wrSelN = !noise; addr = noise ? ~rdA : rdA;
    din = carryD[2*W-1:W]; bwN = carryB[3:2];
    @(negedge clk);
    // phase 2: write slot, beat 0
    rdSelN = !noise; wrSelN = !wrEn; addr = wrA;
    din = dq[W-1:0]; bwN = bq[1:0];
    @(negedge clk);
    // phase 3: beat 1
    rdSelN = !noise; wrSelN = !noise; addr = noise ? ~wrA : wrA;
    din = dq[2*W-1:W]; bwN = bq[3:2];
    if (wrEn) begin
      for (int b = 0; b < 4; b++)
        for (int k = 0; k < 2; k++)
          if (!bq[2*b+k])
            shadow[{wrA, 2'(b)}][k*LANE +: LANE] = dq[b*W + k*LANE +: LANE];
      carryD = dq[4*W-1:2*W];
      carryB = bq[7:4];
    end else begin
      carryD = '0;
      carryB = 4'hF;
    end
    @(negedge clk);
  endtask

  function automatic logic [4*W-1:0] patFor(input int a, input int s);
    logic [4*W-1:0] v;
    for (int b = 0; b < 4; b++) v[b*W +: W] = W'(a * 4099 + b * 77 + s * 311 + 5);
    return v;
  endfunction

  initial begin
    fork
      begin
        #(PERIOD * 200000);
        if (!done) begin
          errors++;
          $display("FAIL R8 watchdog expired");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none

    rst = 1'b1; rdSelN = 1'b1; wrSelN = 1'b1; addr = '0; din = '0; bwN = 2'b11;
    for (int i = 0; i < 64; i++) begin expV[i] = 1'b0; expD[i] = '0; end
    repeat (4) @(negedge clk);
    // R9 reset state
    check(doutValid == 1'b0, "R9", "valid in reset", W'(doutValid), '0);
    check(dout == '0, "R9", "data in reset", dout, '0);
    check(cyclePhase == 2'd0, "R9", "phase in reset", W'(cyclePhase), '0);
    check(echoStrobe == 1'b0, "R9", "echo in reset", W'(echoStrobe), '0);
    rst = 1'b0;
    monOn = 1'b1;

    // Fill every group; each frame also reads the group written one frame earlier (R7 forwarding, R8 back-to-back)
    for (int a = 0; a < DEPTH; a++)
      frame(a > 0, AW'(a - 1), 1'b1, AW'(a), 1'b0, patFor(a, 0), 8'h00);
    frame(1'b1, AW'(DEPTH - 1), 1'b0, '0, 1'b0, '0, 8'hFF);

    // R4 lane masks, R2/R3 select noise, R7 same-frame and next-frame hazards
    begin
      logic [AW-1:0] prevWr;
      prevWr = '0;
      for (int i = 0; i < 96; i++) begin
        logic [4*W-1:0] dq;
        logic [7:0]     bq;
        logic [AW-1:0]  wa, ra;
        dq = {nextRand(), nextRand(), nextRand()}[4*W-1:0];
        bq = nextRand()[15:8];
        if (i % 9 == 0) bq = 8'hFF;          // R4 nothing written
        wa = AW'(i % DEPTH);
        ra = nextRand()[11:8];
        if (i % 2 == 1) ra = prevWr;          // R7 read right after write
        if (i % 7 == 0) ra = wa;              // R7 later write must not leak
        frame(i % 3 != 2, ra, i % 4 != 3, wa, i % 5 == 0, dq, bq);
        prevWr = wa;
      end
    end

    // R5 full read sweep, with gaps to exercise burst edges (R6)
    for (int a = 0; a < DEPTH; a++) frame(1'b1, AW'(a), 1'b0, '0, 1'b0, '0, 8'hFF);
    for (int a = 0; a < DEPTH; a++) begin
      frame(1'b1, AW'(DEPTH - 1 - a), 1'b0, '0, 1'b0, '0, 8'hFF);
      frame(1'b0, '0, 1'b0, '0, 1'b0, '0, 8'hFF);
    end
    repeat (3) frame(1'b0, '0, 1'b0, '0, 1'b0, '0, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule